// File: doc/BRIEF.md
# Inset Window Border and Background Mixer

This block picks the final colour of every output pixel in the path of a picture-in-picture compositor. On each clock it takes the current raster position, the inset window rectangle and the inset video sample in YUV. It decides whether the pixel shows inset video, a coloured outer border, the thin separator lines between tiles of a multi-window layout, a background colour, or black. It then registers the chosen YUV triple.

Border and background colours are held as short fields that fill the upper bits of each 8-bit component, and the lower bits are zero. Chroma is offset-binary, so neutral chroma is 128. The border thickness is set separately for the columns and for the lines. In multi-window mode the window is cut into a grid of tiles of programmable pitch. One tile is the "selected" tile, and it can be blanked to background or have its border drawn at peak luminance. In single-window mode the whole window counts as the selected tile.

Top module: `pip_overlay_mixer`

## Requirements
- R1: While reset is asserted the output is black: Y=0, U=128, V=128.
- R2: The output for a position appears on the first rising clock edge after that position is presented, and not before.
- R3: With the border enabled, a pixel inside the window whose column offset from the left or right edge is below the horizontal width, or whose line offset from the top or bottom edge is below the vertical width, shows the border colour {fy,0000}, {fu,0000}, {fv,0000}. The two widths act independently, and a width of 0 draws no border on that axis.
- R4: In single-window mode a pixel outside the window shows the background colour {by,000000}, {bu,000000}, {bv,000000}.
- R5: In multi-window mode a pixel outside the window shows black when the background select bit is 0, and the background colour when it is 1.
- R6: In multi-window mode with the separator enabled, for each k from 1 to NT-1, pixels whose column offset dx lies in [k*tile_w-2, k*tile_w+1] (4 columns) or whose line offset dy lies in [k*tile_h-1, k*tile_h] (2 lines) show the border colour. In single-window mode, or with the separator disabled, these pixels show no separator.
- R7: A pixel's tile column is the number of k (1..NT-1) with dx >= k*tile_w, and its row is counted the same way from dy. With blank enabled, video pixels of the selected tile show the background colour, and other tiles keep video.
- R8: With highlight enabled, border and separator pixels that belong to the selected tile (per R7) show Y=255 with the border U and V. Border pixels of other tiles keep the programmed Y.
- R9: Priority is outer border, then separator, then blank, then video, then outside-window colour.
- R10: Any other pixel inside the window passes the video sample through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| px_x | input | XW | Current pixel column |
| px_y | input | YW | Current line |
| win_x0 | input | XW | Window left column (inclusive) |
| win_y0 | input | YW | Window top line (inclusive) |
| win_x1 | input | XW | Window right column (inclusive) |
| win_y1 | input | YW | Window bottom line (inclusive) |
| frm_en | input | 1 | Outer border enable |
| frm_wh | input | FWW | Border width in columns |
| frm_wv | input | FWW | Border height in lines |
| frm_y | input | CW | Border Y upper bits |
| frm_u | input | CW | Border U upper bits |
| frm_v | input | CW | Border V upper bits |
| bg_y | input | BGW | Background Y upper bits |
| bg_u | input | BGW | Background U upper bits |
| bg_v | input | BGW | Background V upper bits |
| multi_en | input | 1 | Multi-window tiling mode |
| inner_en | input | 1 | Separator lines enable |
| mbg_sel | input | 1 | Multi-window outside: 0 black, 1 background |
| tile_w | input | XW | Tile pitch in columns |
| tile_h | input | YW | Tile pitch in lines |
| sel_col | input | IW | Selected tile column |
| sel_row | input | IW | Selected tile row |
| blank_en | input | 1 | Blank selected tile to background |
| hl_en | input | 1 | Highlight selected tile border |
| vid_y | input | PIX_W | Inset video Y |
| vid_u | input | PIX_W | Inset video U |
| vid_v | input | PIX_W | Inset video V |
| out_y | output | PIX_W | Output Y |
| out_u | output | PIX_W | Output U |
| out_v | output | PIX_W | Output V |

## Verification
The bench probes the border edges one pixel either side on all four sides. An off-by-one compare would show video where border belongs, or border one pixel too far in. It sets each width to zero on its own, so that a swapped or shared width register is caught. It walks across a separator column pair, where an error in tile attribution would highlight the wrong half. It also stacks blank, separator and highlight on the same pixel to expose a wrong priority order, and checks the output edge to catch a missing or extra register stage.

// File: rtl/pip_ovl_pkg.sv
package pip_ovl_pkg;
    parameter int PIX_W = 8;

    typedef struct packed {
        logic [PIX_W-1:0] y;
        logic [PIX_W-1:0] u;
        logic [PIX_W-1:0] v;
    } pix_t;

    localparam logic [PIX_W-1:0] CHROMA_MID = PIX_W'(1) << (PIX_W - 1);
    localparam pix_t BLACK_PIX = {{PIX_W{1'b0}}, CHROMA_MID, CHROMA_MID};

    typedef struct packed {
        pix_t pix;
        logic primed;
    } mix_state_t;
endpackage

// File: rtl/ovl_geom.sv
module ovl_geom #(
    parameter int XW  = 10,
    parameter int YW  = 10,
    parameter int FWW = 4
) (
    input  logic [XW-1:0]  px_x,
    input  logic [YW-1:0]  px_y,
    input  logic [XW-1:0]  win_x0,
    input  logic [YW-1:0]  win_y0,
    input  logic [XW-1:0]  win_x1,
    input  logic [YW-1:0]  win_y1,
    input  logic           frm_en,
    input  logic [FWW-1:0] frm_wh,
    input  logic [FWW-1:0] frm_wv,
    output logic           in_win,
    output logic           in_frame,
    output logic [XW-1:0]  dx,
    output logic [YW-1:0]  dy
);
    logic [XW-1:0] dx_r;
    logic [YW-1:0] dy_b;
    logic          edge_h, edge_v;

    always_comb begin
        in_win   = (px_x >= win_x0) && (px_x <= win_x1) &&
                   (px_y >= win_y0) && (px_y <= win_y1);
        dx       = px_x - win_x0;
        dy       = px_y - win_y0;
        dx_r     = win_x1 - px_x;
        dy_b     = win_y1 - px_y;
        edge_h   = (dx < XW'(frm_wh)) || (dx_r < XW'(frm_wh));
        edge_v   = (dy < YW'(frm_wv)) || (dy_b < YW'(frm_wv));
        in_frame = frm_en && in_win && (edge_h || edge_v);
    end
endmodule

// File: rtl/ovl_tile.sv
module ovl_tile #(
    parameter int XW = 10,
    parameter int YW = 10,
    parameter int NT = 3,
    parameter int IW = 2
) (
    input  logic [XW-1:0] dx,
    input  logic [YW-1:0] dy,
    input  logic [XW-1:0] tile_w,
    input  logic [YW-1:0] tile_h,
    input  logic [IW-1:0] sel_col,
    input  logic [IW-1:0] sel_row,
    input  logic          multi_en,
    input  logic          inner_en,
    input  logic          in_win,
    output logic          in_inner,
    output logic          is_sel
);
    localparam int XE = XW + IW + 2;
    localparam int YE = YW + IW + 2;
    localparam int NB = NT - 1;

    logic [NB-1:0] past_c, past_r, band_c, band_r;
    logic [IW-1:0] col, row;
    logic [XE-1:0] dxe;
    logic [YE-1:0] dye;

    assign dxe = XE'(dx);
    assign dye = YE'(dy);

    for (genvar k = 1; k < NT; k++) begin : g_bound
        logic [XE-1:0] bx;
        logic [YE-1:0] by;
        assign bx = XE'(k) * XE'(tile_w);
        assign by = YE'(k) * YE'(tile_h);
        assign past_c[k-1] = dxe >= bx;
        assign past_r[k-1] = dye >= by;
        assign band_c[k-1] = (dxe + XE'(2) >= bx) && (dxe <= bx + XE'(1));
        assign band_r[k-1] = (dye + YE'(1) >= by) && (dye <= by);
    end

    always_comb begin
        col = '0;
        row = '0;
        for (int i = 0; i < NB; i++) begin
            col = col + IW'(past_c[i]);
            row = row + IW'(past_r[i]);
        end
        is_sel   = !multi_en || ((col == sel_col) && (row == sel_row));
        in_inner = multi_en && inner_en && in_win && ((|band_c) || (|band_r));
    end
endmodule

// File: rtl/ovl_colour.sv
module ovl_colour
    import pip_ovl_pkg::*;
#(
    parameter int CW  = 4,
    parameter int BGW = 2
) (
    input  logic [CW-1:0]  frm_y,
    input  logic [CW-1:0]  frm_u,
    input  logic [CW-1:0]  frm_v,
    input  logic [BGW-1:0] bg_y,
    input  logic [BGW-1:0] bg_u,
    input  logic [BGW-1:0] bg_v,
    output pix_t           frm_pix,
    output pix_t           bg_pix
);
    localparam int FPAD = PIX_W - CW;
    localparam int BPAD = PIX_W - BGW;

    always_comb begin
        frm_pix.y = {frm_y, {FPAD{1'b0}}};
        frm_pix.u = {frm_u, {FPAD{1'b0}}};
        frm_pix.v = {frm_v, {FPAD{1'b0}}};
        bg_pix.y  = {bg_y, {BPAD{1'b0}}};
        bg_pix.u  = {bg_u, {BPAD{1'b0}}};
        bg_pix.v  = {bg_v, {BPAD{1'b0}}};
    end
endmodule

// File: rtl/pip_overlay_mixer.sv
module pip_overlay_mixer
    import pip_ovl_pkg::*;
#(
    parameter int XW  = 10,
    parameter int YW  = 10,
    parameter int FWW = 4,
    parameter int CW  = 4,
    parameter int BGW = 2,
    parameter int NT  = 3,
    localparam int IW = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [XW-1:0]    px_x,
    input  logic [YW-1:0]    px_y,
    input  logic [XW-1:0]    win_x0,
    input  logic [YW-1:0]    win_y0,
    input  logic [XW-1:0]    win_x1,
    input  logic [YW-1:0]    win_y1,
    input  logic             frm_en,
    input  logic [FWW-1:0]   frm_wh,
    input  logic [FWW-1:0]   frm_wv,
    input  logic [CW-1:0]    frm_y,
    input  logic [CW-1:0]    frm_u,
    input  logic [CW-1:0]    frm_v,
    input  logic [BGW-1:0]   bg_y,
    input  logic [BGW-1:0]   bg_u,
    input  logic [BGW-1:0]   bg_v,
    input  logic             multi_en,
    input  logic             inner_en,
    input  logic             mbg_sel,
    input  logic [XW-1:0]    tile_w,
    input  logic [YW-1:0]    tile_h,
    input  logic [IW-1:0]    sel_col,
    input  logic [IW-1:0]    sel_row,
    input  logic             blank_en,
    input  logic             hl_en,
    input  logic [PIX_W-1:0] vid_y,
    input  logic [PIX_W-1:0] vid_u,
    input  logic [PIX_W-1:0] vid_v,
    output logic [PIX_W-1:0] out_y,
    output logic [PIX_W-1:0] out_u,
    output logic [PIX_W-1:0] out_v
);
    logic          in_win, in_frame, in_inner, is_sel;
    logic [XW-1:0] dx;
    logic [YW-1:0] dy;
    pix_t          frm_pix, bg_pix, vid_pix;
    mix_state_t    st_d, st_q;

    ovl_geom #(.XW(XW), .YW(YW), .FWW(FWW)) u_geom (
        .px_x(px_x), .px_y(px_y),
        .win_x0(win_x0), .win_y0(win_y0), .win_x1(win_x1), .win_y1(win_y1),
        .frm_en(frm_en), .frm_wh(frm_wh), .frm_wv(frm_wv),
        .in_win(in_win), .in_frame(in_frame), .dx(dx), .dy(dy)
    );

    ovl_tile #(.XW(XW), .YW(YW), .NT(NT), .IW(IW)) u_tile (
        .dx(dx), .dy(dy), .tile_w(tile_w), .tile_h(tile_h),
        .sel_col(sel_col), .sel_row(sel_row),
        .multi_en(multi_en), .inner_en(inner_en), .in_win(in_win),
        .in_inner(in_inner), .is_sel(is_sel)
    );

    ovl_colour #(.CW(CW), .BGW(BGW)) u_colour (
        .frm_y(frm_y), .frm_u(frm_u), .frm_v(frm_v),
        .bg_y(bg_y), .bg_u(bg_u), .bg_v(bg_v),
        .frm_pix(frm_pix), .bg_pix(bg_pix)
    );

    assign vid_pix = {vid_y, vid_u, vid_v};

    // Priority ladder: outer border, separator, blank, video, outside colour
    always_comb begin
        st_d        = st_q;
        st_d.primed = 1'b1;
        if (in_frame || in_inner) begin
            st_d.pix = frm_pix;
            if (hl_en && is_sel) st_d.pix.y = '1;
        end else if (in_win && blank_en && is_sel) begin
            st_d.pix = bg_pix;
        end else if (in_win) begin
            st_d.pix = vid_pix;
        end else if (multi_en && !mbg_sel) begin
            st_d.pix = BLACK_PIX;
        end else begin
            st_d.pix = bg_pix;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pix    <= BLACK_PIX;
            st_q.primed <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_y = st_q.pix.y;
    assign out_u = st_q.pix.u;
    assign out_v = st_q.pix.v;

    // R4
    single_outside_bg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.primed && $past(!in_win && !multi_en)) |->
        ({out_y, out_u, out_v} == $past(bg_pix)));

    // R5
    multi_outside_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.primed && $past(!in_win && multi_en && !mbg_sel)) |->
        ({out_y, out_u, out_v} == BLACK_PIX));

    // R8
    highlight_peak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.primed && $past((in_frame || in_inner) && hl_en && is_sel)) |->
        (out_y == {PIX_W{1'b1}}));

    // R3
    frame_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.primed && $past(in_frame && !hl_en)) |->
        (out_y[PIX_W-CW-1:0] == '0 && out_u[PIX_W-CW-1:0] == '0 &&
         out_v[PIX_W-CW-1:0] == '0));

    // R10
    video_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.primed && $past(in_win && !in_frame && !in_inner && !(blank_en && is_sel))) |->
        ({out_y, out_u, out_v} == $past(vid_pix)));

    // R6
    inner_needs_multi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_inner |-> (multi_en && inner_en && in_win));
endmodule

// File: tb/pip_overlay_mixer_tb.sv
module pip_overlay_mixer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] px_x = '0, px_y = '0;
    logic [9:0] win_x0 = 10'd100, win_y0 = 10'd50, win_x1 = 10'd199, win_y1 = 10'd129;
    logic       frm_en = 1'b1;
    logic [3:0] frm_wh = 4'd3, frm_wv = 4'd2;
    logic [3:0] frm_y = 4'hA, frm_u = 4'h5, frm_v = 4'hC;
    logic [1:0] bg_y = 2'd1, bg_u = 2'd2, bg_v = 2'd3;
    logic       multi_en = 1'b0, inner_en = 1'b0, mbg_sel = 1'b0;
    logic [9:0] tile_w = 10'd30, tile_h = 10'd20;
    logic [1:0] sel_col = 2'd1, sel_row = 2'd1;
    logic       blank_en = 1'b0, hl_en = 1'b0;
    logic [7:0] vid_y = 8'h77, vid_u = 8'h88, vid_v = 8'h99;
    logic [7:0] out_y, out_u, out_v;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    pip_overlay_mixer u_dut (
        .clk(clk), .rst_n(rst_n), .px_x(px_x), .px_y(px_y),
        .win_x0(win_x0), .win_y0(win_y0), .win_x1(win_x1), .win_y1(win_y1),
        .frm_en(frm_en), .frm_wh(frm_wh), .frm_wv(frm_wv),
        .frm_y(frm_y), .frm_u(frm_u), .frm_v(frm_v),
        .bg_y(bg_y), .bg_u(bg_u), .bg_v(bg_v),
        .multi_en(multi_en), .inner_en(inner_en), .mbg_sel(mbg_sel),
        .tile_w(tile_w), .tile_h(tile_h), .sel_col(sel_col), .sel_row(sel_row),
        .blank_en(blank_en), .hl_en(hl_en),
        .vid_y(vid_y), .vid_u(vid_u), .vid_v(vid_v),
        .out_y(out_y), .out_u(out_u), .out_v(out_v)
    );

    localparam logic [23:0] FRM = 24'hA0_50_C0;
    localparam logic [23:0] FHL = 24'hFF_50_C0;
    localparam logic [23:0] BGC = 24'h40_80_C0;
    localparam logic [23:0] VID = 24'h77_88_99;
    localparam logic [23:0] BLK = 24'h00_80_80;

    typedef struct packed {
        logic [9:0]  x;
        logic [9:0]  y;
        logic [23:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{10'd10,  10'd10,  BGC, 4'd4},   // R4 outside
        '{10'd100, 10'd60,  FRM, 4'd3},   // R3 left edge
        '{10'd102, 10'd60,  FRM, 4'd3},   // R3 last border column
        '{10'd103, 10'd60,  VID, 4'd10},  // R10 first video column
        '{10'd150, 10'd51,  FRM, 4'd3},   // R3 top border line
        '{10'd150, 10'd52,  VID, 4'd10},  // R10
        '{10'd199, 10'd90,  FRM, 4'd3},   // R3 right edge
        '{10'd197, 10'd90,  FRM, 4'd3},   // R3
        '{10'd196, 10'd90,  VID, 4'd10},  // R10
        '{10'd150, 10'd128, FRM, 4'd3},   // R3 bottom
        '{10'd150, 10'd127, VID, 4'd10},  // R10
        '{10'd200, 10'd90,  BGC, 4'd4},   // R4 just right of window
        '{10'd150, 10'd49,  BGC, 4'd4}    // R4 just above window
    };

    task automatic check(input logic [23:0] exp, input int req, input string what);
        n_run++;
        if ({out_y, out_u, out_v} !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: got %h expected %h", req, what, {out_y, out_u, out_v}, exp);
        end
    endtask

    task automatic step(input logic [9:0] x, input logic [9:0] y);
        @(negedge clk);
        px_x = x;
        px_y = y;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(BLK, 1, "output black in reset");            // R1
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].x, VECS[i].y);
            check(VECS[i].exp, int'(VECS[i].req), "table vector");
        end

        // R2 latency: value changes only at the next rising edge
        step(10'd10, 10'd10);
        @(negedge clk);
        px_x = 10'd150; px_y = 10'd90;
        #1;
        check(BGC, 2, "output before edge holds old value");
        @(posedge clk); #1;
        check(VID, 2, "output after edge shows new value");

        // R3 independent widths
        frm_wh = 4'd0; frm_wv = 4'd0;
        step(10'd100, 10'd50);
        check(VID, 3, "zero widths draw no border");
        frm_wv = 4'd2;
        step(10'd100, 10'd50);
        check(FRM, 3, "vertical width alone");
        step(10'd100, 10'd52);
        check(VID, 3, "horizontal width zero");
        frm_en = 1'b0;
        step(10'd100, 10'd50);
        check(VID, 3, "border disabled");
        frm_en = 1'b1; frm_wh = 4'd3;

        // R6 separator in multi mode, tile pitch 30 x 20
        multi_en = 1'b1; inner_en = 1'b1;
        step(10'd127, 10'd75); check(VID, 6, "column before separator");
        step(10'd128, 10'd75); check(FRM, 6, "separator first column");
        step(10'd131, 10'd75); check(FRM, 6, "separator last column");
        step(10'd132, 10'd75); check(VID, 6, "column after separator");
        step(10'd150, 10'd68); check(VID, 6, "line before separator");
        step(10'd150, 10'd69); check(FRM, 6, "separator first line");

        // R5 outside colour in multi mode
        step(10'd10, 10'd10); check(BLK, 5, "multi outside black");
        mbg_sel = 1'b1;
        step(10'd10, 10'd10); check(BGC, 5, "multi outside background");

        // R7 blank selected tile (1,1)
        blank_en = 1'b1;
        step(10'd145, 10'd80); check(BGC, 7, "selected tile blanked");
        step(10'd110, 10'd60); check(VID, 7, "other tile keeps video");
        // R9 separator wins over blank
        step(10'd130, 10'd80); check(FRM, 9, "separator over blank");

        // R8 highlight of selected tile
        blank_en = 1'b0; hl_en = 1'b1;
        step(10'd130, 10'd80); check(FHL, 8, "selected tile separator peak Y");
        step(10'd129, 10'd80); check(FRM, 8, "neighbour tile separator normal");
        inner_en = 1'b0;
        step(10'd130, 10'd80); check(VID, 6, "separator disabled");

        // single mode: separator ignored, whole window selected
        multi_en = 1'b0; inner_en = 1'b1;
        step(10'd130, 10'd80); check(VID, 6, "separator ignored in single mode");
        step(10'd100, 10'd80); check(FHL, 8, "single mode border highlighted");
        blank_en = 1'b1;
        step(10'd150, 10'd90); check(BGC, 7, "single mode window blanked");
        step(10'd100, 10'd80); check(FHL, 9, "border over blank");
        hl_en = 1'b0;
        step(10'd100, 10'd80); check(FRM, 9, "border over blank no highlight");

        // R1 reset again mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(BLK, 1, "asynchronous reset clears output");
        @(negedge clk);
        rst_n = 1'b1;

        finish_run();
    end
endmodule